// File: doc/BRIEF.md
# Low-Power Overcurrent Wake Monitor

This block watches the supply-current comparator while the device rests in a low-power state with its regulator still on. It measures how long each overcurrent episode lasts. A 2-bit mode field and a watchdog-enable flag decide what that length means. The episode can have no effect, it can become a single wake pulse once it outlasts a limit, or, when it is short enough, it can count as one watchdog refresh at the moment it ends.

The comparator level is asynchronous and passes through a synchronizer chain before it is measured. Two duration limits are available. The short limit is a fixed tick count that stands for roughly 100 µs. The programmable limit is picked by a 3-bit select from a computed table that spans 3 ms to 32 ms. The duration counter clears whenever the comparator drops or the low-power flag is removed.

Top module: `lp_oc_wake_mon`

## Requirements
- R1: After reset, wake_pulse and refresh_pulse are both 0.
- R2: With oc_mode 2'b00 or 2'b01, no episode of any length produces a wake_pulse or a refresh_pulse, whatever wd_en is.
- R3: With oc_mode 2'b10, an episode whose synchronized length exceeds SHORT_TICKS cycles produces exactly one wake_pulse. An episode of SHORT_TICKS cycles or fewer produces none.
- R4: With oc_mode 2'b11, the limit is MS_TICKS * m clock cycles. Here m is 3 + 4*dur_sel for dur_sel 0 to 6, and 32 for dur_sel 7. An episode longer than the limit produces exactly one wake_pulse.
- R5: With oc_mode 2'b11 and wd_en 1, an episode of 1 to limit cycles produces exactly one refresh_pulse and no wake_pulse. An episode that has caused a wake produces no refresh.
- R6: With wd_en 0, or with oc_mode 2'b10, no refresh_pulse is ever produced.
- R7: Each pulse is one cycle wide. A single continuous episode gives at most one wake_pulse.
- R8: While lp_active is 0, nothing is produced. Dropping lp_active during an episode cancels that episode, so neither a wake nor a refresh follows from it.
- R9: Latency counts from the first clock edge that samples oc_raw high (edge 1) in an episode of N sampled cycles. The wake_pulse is high after edge limit+3, and the refresh_pulse is high after edge N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_active | input | 1 | Low-power state with regulator on |
| wd_en | input | 1 | Watchdog enabled |
| oc_mode | input | 2 | Overcurrent handling mode |
| oc_raw | input | 1 | Asynchronous comparator level |
| dur_sel | input | 3 | Programmable duration select |
| wake_pulse | output | 1 | One-cycle wake event |
| refresh_pulse | output | 1 | One-cycle watchdog refresh |

## Verification
A duration counter that is off by one shows up as a wake or a refresh on the wrong side of a limit. The sweep catches it by driving lengths of limit-1, limit and limit+1 for every select. A bad table entry or a bad synchronizer depth moves the first pulse away from its predicted cycle, and that is visible within a few cycles of the limit. A stale fired flag or a counter that is not cleared shows up as missing or doubled pulses in the episode that follows. The cancel test catches a counter that survives the low-power exit.

// File: rtl/lp_oc_pkg.sv
package lp_oc_pkg;

   typedef enum logic [1:0] {
      OC_IGNORE_A = 2'b00,
      OC_IGNORE_B = 2'b01,
      OC_SHORT    = 2'b10,
      OC_PROG     = 2'b11
   } oc_mode_e;

   localparam int unsigned PROG_ENTRIES = 8;

   // programmable limit in milliseconds for a select value
   function automatic int unsigned prog_ms(input int unsigned sel);
      return (sel == PROG_ENTRIES - 1) ? 32 : 3 + 4 * sel;
   endfunction

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("oc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/oc_dur_cnt.sv
module oc_dur_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt <= limit)   cnt <= cnt + 1'b1;
   end

   // the counter never climbs more than one step past the limit it follows
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $stable(limit) && $past(cnt) > $past(limit)) |-> $stable(cnt));

endmodule

// File: rtl/oc_decide.sv
module oc_decide
   import lp_oc_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_active,
   input  logic             oc_s,
   input  logic             wd_en,
   input  oc_mode_e         mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] limit,
   output logic             wake,
   output logic             refresh
);

   logic fired;
   logic wake_arm;
   logic refresh_arm;

   always_comb begin
      wake_arm    = lp_active && oc_s && mode[1] && (cnt == limit) && !fired;
      refresh_arm = lp_active && !oc_s && (mode == OC_PROG) && wd_en &&
                    (cnt != '0) && (cnt <= limit) && !fired;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired   <= 1'b0;
         wake    <= 1'b0;
         refresh <= 1'b0;
      end else begin
         wake    <= wake_arm;
         refresh <= refresh_arm;
         if (!lp_active || !oc_s) fired <= 1'b0;
         else if (wake_arm)       fired <= 1'b1;
      end
   end

   assert_wake_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);
   assert_refresh_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |=> !refresh);
   assert_quiet_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wake || refresh) |-> $past(mode[1]));
   assert_refresh_needs_wd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |-> ($past(wd_en) && $past(mode) == OC_PROG));
   assert_lp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake || refresh) |-> $past(lp_active));
   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake && refresh));

endmodule

// File: rtl/lp_oc_wake_mon.sv
module lp_oc_wake_mon
   import lp_oc_pkg::*;
#(
   parameter int unsigned SHORT_TICKS = 20000,
   parameter int unsigned MS_TICKS    = 200000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lp_active,
   input  logic       wd_en,
   input  logic [1:0] oc_mode,
   input  logic       oc_raw,
   input  logic [2:0] dur_sel,
   output logic       wake_pulse,
   output logic       refresh_pulse
);

   localparam int unsigned MAX_LIMIT = (MS_TICKS * 32 > SHORT_TICKS) ?
                                       MS_TICKS * 32 : SHORT_TICKS;
   localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 2);

   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (MS_TICKS < 1) begin : g_bad_ms
         $error("MS_TICKS must be at least 1");
      end
   endgenerate

   oc_mode_e mode;
   assign mode = oc_mode_e'(oc_mode);

   logic oc_s;

   oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (oc_raw),
      .q_sync  (oc_s)
   );

   logic [CNT_W-1:0] lim_tab [PROG_ENTRIES];

   generate
      for (genvar g = 0; g < PROG_ENTRIES; g++) begin : g_tab
         assign lim_tab[g] = CNT_W'(MS_TICKS * prog_ms(g));
      end
   endgenerate

   logic [CNT_W-1:0] limit;
   assign limit = (mode == OC_PROG) ? lim_tab[dur_sel] : CNT_W'(SHORT_TICKS);

   logic [CNT_W-1:0] cnt;

   oc_dur_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (lp_active && oc_s),
      .limit (limit),
      .cnt   (cnt)
   );

   oc_decide #(.CNT_W(CNT_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .lp_active (lp_active),
      .oc_s      (oc_s),
      .wd_en     (wd_en),
      .mode      (mode),
      .cnt       (cnt),
      .limit     (limit),
      .wake      (wake_pulse),
      .refresh   (refresh_pulse)
   );

endmodule

// File: tb/test_lp_oc_wake_mon.sv
module test_lp_oc_wake_mon;

   localparam int SHORT = 10;
   localparam int MSU   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_active = 1'b0;
   logic       wd_en = 1'b0;
   logic [1:0] oc_mode = 2'b00;
   logic       oc_raw = 1'b0;
   logic [2:0] dur_sel = 3'd0;
   logic       wake_pulse;
   logic       refresh_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   lp_oc_wake_mon #(.SHORT_TICKS(SHORT), .MS_TICKS(MSU), .SYNC_STAGES(2)) i_lp_oc_wake_mon (
      .clk           (clk),
      .rst_n         (rst_n),
      .lp_active     (lp_active),
      .wd_en         (wd_en),
      .oc_mode       (oc_mode),
      .oc_raw        (oc_raw),
      .dur_sel       (dur_sel),
      .wake_pulse    (wake_pulse),
      .refresh_pulse (refresh_pulse)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_limit(input int mode, input int sel);
      if (mode == 3) return MSU * ((sel == 7) ? 32 : 3 + 4 * sel);
      return SHORT;
   endfunction

   // drives one episode of n sampled high cycles, lp may drop at index drop
   task automatic run_ep(input int n, input int drop,
                         output int wn, output int wi, output int rn, output int ri);
      int span;
      wn = 0; wi = 0; rn = 0; ri = 0;
      span = n + 10;
      @(negedge clk);
      oc_raw = 1'b1;
      for (int i = 1; i <= span; i++) begin
         @(negedge clk);
         if (wake_pulse)    begin wn++; wi = i; end
         if (refresh_pulse) begin rn++; ri = i; end
         oc_raw = (i < n);
         if (drop != 0 && i == drop) lp_active = 1'b0;
      end
   endtask

   initial begin
      int wn, wi, rn, ri, lim, ew, er;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(wake_pulse == 1'b0, "R1 wake after reset", wake_pulse, 0);
      chk(refresh_pulse == 1'b0, "R1 refresh after reset", refresh_pulse, 0);
      rst_n = 1'b1;
      lp_active = 1'b1;
      repeat (2) @(negedge clk);

      for (int wd = 0; wd < 2; wd++) begin
         for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
               wd_en   = wd[0];
               oc_mode = m[1:0];
               dur_sel = s[2:0];
               lim = exp_limit(m, s);
               for (int k = 0; k < 5; k++) begin
                  int n;
                  case (k)
                     0: n = 1;
                     1: n = lim - 1;
                     2: n = lim;
                     3: n = lim + 1;
                     default: n = lim + 5;
                  endcase
                  run_ep(n, 0, wn, wi, rn, ri);
                  ew = (m >= 2 && n > lim) ? 1 : 0;
                  er = (m == 3 && wd == 1 && n <= lim) ? 1 : 0;
                  if (m < 2) begin
                     chk(wn == 0, "R2 no wake in quiet mode", wn, 0);
                     chk(rn == 0, "R2 no refresh in quiet mode", rn, 0);
                  end else if (m == 2) begin
                     chk(wn == ew, "R3 short-limit wake count", wn, ew);
                     chk(rn == 0, "R6 no refresh in short mode", rn, 0);
                  end else begin
                     chk(wn == ew, "R4 programmable wake count", wn, ew);
                     if (wd == 1) chk(rn == er, "R5 refresh count", rn, er);
                     else         chk(rn == 0, "R6 no refresh with watchdog off", rn, 0);
                  end
                  chk(wn <= 1, "R7 single wake per episode", wn, 1);
                  if (ew == 1) chk(wi == lim + 3, "R9 wake latency", wi, lim + 3);
                  if (er == 1) chk(ri == n + 3, "R9 refresh latency", ri, n + 3);
               end
            end
         end
      end

      // R8 low-power inactive: nothing
      lp_active = 1'b0;
      wd_en = 1'b1; oc_mode = 2'b10; dur_sel = 3'd0;
      run_ep(SHORT + 20, 0, wn, wi, rn, ri);
      chk(wn == 0, "R8 no wake outside low power", wn, 0);
      oc_mode = 2'b11;
      run_ep(3, 0, wn, wi, rn, ri);
      chk(rn == 0, "R8 no refresh outside low power", rn, 0);

      // R8 leaving low power mid-episode cancels it
      lp_active = 1'b1;
      repeat (2) @(negedge clk);
      run_ep(20, 5, wn, wi, rn, ri);
      chk(wn == 0, "R8 cancelled episode wake", wn, 0);
      chk(rn == 0, "R8 cancelled episode refresh", rn, 0);
      lp_active = 1'b1;
      repeat (4) @(negedge clk);
      run_ep(4, 0, wn, wi, rn, ri);
      chk(rn == 1 && ri == 7, "R5 refresh after cancel", ri, 7);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule